// File: doc/BRIEF.md
# Source Word Alignment Funnel Shifter

This block lines up a stream of 16-bit source words to a destination pixel boundary during a bit-block transfer. It keeps the previous source word in a latch. Each new source word is joined with that latched word, and a 16-bit window is cut from the pair by a 4-bit shift count held in a control register. A select pin chooses which of the two words fills the upper half of the window, so both left-to-right and right-to-left transfers can be aligned.

The aligned word can be appended to a 16-entry circular queue, which a downstream raster-operation stage drains through a pop port. The head entry is always visible on the output. A pop consumes it in the same cycle. A write can also only prime the latch without queueing anything, which is how the first word of a scan line is loaded.

Top module: `blt_src_align`

## Requirements
- R1: After reset the queue is empty (`q_empty`=1, `q_full`=0), the shift count is 0 and the previous-word latch holds 0.
- R2: A control write (`ctl_wr`=1) loads the shift count n from `ctl_data[11:8]`; the other control bits have no effect. The new count applies from the next cycle on.
- R3: With `src_sel`=1 the aligned word is (new word << n) | (latched word >> (16 − n)), truncated to 16 bits.
- R4: With `src_sel`=0 the aligned word is (latched word << n) | (new word >> (16 − n)), truncated to 16 bits.
- R5: With n = 0 the aligned word equals the upper-half operand: the new word when `src_sel`=1, the latched word when `src_sel`=0.
- R6: Every source write (`src_wr`=1) stores `src_data` in the latch, whether or not `src_push` is set and whether or not the push is accepted.
- R7: A source write with `src_push`=1 appends the aligned word at the queue tail. Words leave in the order they were appended, and the pointers wrap modulo 16.
- R8: `pop_data` shows the head entry whenever the queue is not empty. `pop`=1 removes that entry at the next clock edge.
- R9: `q_full` rises when the sixteenth word is stored. `q_empty` means that no word is held. An accepted pop with no push clears `q_full`.
- R10: A push while the queue is full and no pop is made is dropped and the queue stays unchanged. A pop while the queue is empty is ignored.
- R11: A push and a pop in the same cycle on a non-empty queue both take effect, and the occupancy is unchanged, including when the queue is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_data | input | 16 | Control word; shift count in bits 11:8 |
| src_wr | input | 1 | Source word write strobe |
| src_push | input | 1 | Append the aligned word to the queue on this write |
| src_sel | input | 1 | 1: new word is the upper part; 0: latched word is the upper part |
| src_data | input | 16 | Incoming source word |
| pop | input | 1 | Remove the head entry |
| pop_data | output | 16 | Head entry of the queue |
| q_empty | output | 1 | Queue holds no word |
| q_full | output | 1 | Queue holds 16 words |

## Verification
The embedded assertions check, on every cycle, how single events affect state: the latch capturing each source word, the control write loading the count field, a lone push leaving the queue non-empty, a lone pop clearing full, a dropped push while full, and the flags holding steady when a push and a pop coincide. The value of each aligned word, FIFO ordering across pointer wrap, and the reset contents are shown only by the bench's scenarios. The bench sweeps all sixteen shift counts at both select levels, fills and drains the queue, and compares every output on every cycle against a behavioural queue model.

// File: rtl/blt_src_align.sv
module blt_src_align #(
  parameter int W      = 16,
  parameter int DEPTH  = 16,
  parameter int SH_LSB = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ctl_wr,
  input  logic [W-1:0] ctl_data,
  input  logic         src_wr,
  input  logic         src_push,
  input  logic         src_sel,
  input  logic [W-1:0] src_data,
  input  logic         pop,
  output logic [W-1:0] pop_data,
  output logic         q_empty,
  output logic         q_full
);
  localparam int SHW = $clog2(W);
  localparam int PW  = $clog2(DEPTH);

  logic [W-1:0]   mem [DEPTH];
  logic [PW-1:0]  head, tail;
  logic           full_q;
  logic [W-1:0]   prev_q;
  logic [SHW-1:0] sh_q;

  logic [W-1:0]   hi_w, lo_w, aligned;
  logic [2*W-1:0] cat;
  logic           pop_ok, push_ok;
  logic [PW-1:0]  tail_inc;

  assign hi_w     = src_sel ? src_data : prev_q;
  assign lo_w     = src_sel ? prev_q : src_data;
  assign cat      = {hi_w, lo_w} << sh_q;
  assign aligned  = cat[2*W-1:W];

  assign q_empty  = !full_q && (head == tail);
  assign q_full   = full_q;
  assign pop_data = mem[head];

  assign pop_ok   = pop && !q_empty;
  assign push_ok  = src_wr && src_push && (!full_q || pop_ok);
  assign tail_inc = PW'(tail + 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head   <= '0;
      tail   <= '0;
      full_q <= 1'b0;
      prev_q <= '0;
      sh_q   <= '0;
    end else begin
      if (ctl_wr) sh_q <= ctl_data[SH_LSB +: SHW];
      if (src_wr) prev_q <= src_data;
      if (pop_ok) head <= PW'(head + 1'b1);
      if (push_ok) tail <= tail_inc;
      if (push_ok && !pop_ok) full_q <= (tail_inc == head);
      else if (pop_ok && !push_ok) full_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[tail] <= aligned;
  end

  // R2
  count_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> sh_q == $past(ctl_data[SH_LSB +: SHW]));

  // R6
  latch_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_wr |=> prev_q == $past(src_data));

  // R9
  push_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_wr && src_push && !q_full && !pop) |=> !q_empty);

  // R9
  pop_unfills_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !q_empty && !(src_wr && src_push)) |=> !q_full);

  // R10
  drop_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_full && !pop && src_wr && src_push) |=> q_full && $stable(tail) && $stable(head));

  // R11
  push_pop_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !q_empty && src_wr && src_push) |=> $stable(q_full) && $stable(q_empty));
endmodule

// File: tb/blt_src_align_bench.sv
module blt_src_align_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        ctl_wr = 0, src_wr = 0, src_push = 0, src_sel = 0, pop = 0;
  logic [15:0] ctl_data = '0, src_data = '0;
  logic [15:0] pop_data;
  logic        q_empty, q_full;

  int compared = 0, mismatched = 0;
  bit done = 0;
  string tag = "R1";

  logic [15:0] q[$];
  logic [15:0] m_prev = '0;
  int          m_sh = 0;

  always #10 clk = ~clk;

  blt_src_align u_blt_src_align (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_data(ctl_data),
    .src_wr(src_wr), .src_push(src_push), .src_sel(src_sel), .src_data(src_data),
    .pop(pop), .pop_data(pop_data), .q_empty(q_empty), .q_full(q_full)
  );

  function automatic logic [15:0] ref_align(logic [15:0] latched, logic [15:0] nw, bit sel, int n);
    int h, l;
    h = sel ? int'(nw) : int'(latched);
    l = sel ? int'(latched) : int'(nw);
    if (n == 0) return 16'(h);
    return 16'(((h << n) | (l >> (16 - n))) & 'hffff);
  endfunction

  task automatic cmp(string what, logic [15:0] act, logic [15:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic check_outputs();
    cmp("q_empty", 16'(q_empty), 16'(q.size() == 0));
    cmp("q_full", 16'(q_full), 16'(q.size() == 16));
    if (q.size() > 0) cmp("pop_data", pop_data, q[0]);
  endtask

  task automatic step(bit cw, logic [15:0] cd, bit sw, bit sp, bit ss,
                      logic [15:0] sd, bit pp);
    bit popped;
    logic [15:0] res;
    ctl_wr = cw; ctl_data = cd; src_wr = sw; src_push = sp;
    src_sel = ss; src_data = sd; pop = pp;
    res = ref_align(m_prev, sd, ss, m_sh);
    popped = 0;
    if (pp && q.size() > 0) begin void'(q.pop_front()); popped = 1; end
    if (sw && sp && q.size() < 16) q.push_back(res);
    if (sw) m_prev = sd;
    if (cw) m_sh = int'(cd[11:8]);
    @(posedge clk);
    @(negedge clk);
    ctl_wr = 0; src_wr = 0; src_push = 0; pop = 0;
    check_outputs();
  endtask

  task automatic set_shift(int n);
    step(1, 16'hA0F5 & ~16'h0F00 | 16'(n << 8), 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    tag = "R1";
    check_outputs();
    // R1: latch 0, shift 0, sel=0 -> result is latched word 0
    step(0, 0, 1, 1, 0, 16'h1234, 0);
    cmp("reset latch result", pop_data, 16'h0000);
    step(0, 0, 0, 0, 0, 0, 1);
    // R2: only bits 11:8 matter
    tag = "R2";
    step(1, 16'hF3AB, 0, 0, 0, 0, 0);
    step(0, 0, 1, 0, 1, 16'hF00F, 0);
    step(0, 0, 1, 1, 1, 16'h1234, 0);
    cmp("shift3 sel1", pop_data, 16'h91A7);
    step(0, 0, 0, 0, 0, 0, 1);
    // R3 R4 R5 R6: sweep all counts, both select levels
    for (int n = 0; n < 16; n++) begin
      for (int s = 0; s < 2; s++) begin
        tag = (n == 0) ? "R5" : (s == 1 ? "R3" : "R4");
        set_shift(n);
        step(0, 0, 1, 0, 1'(s), 16'(16'hC3A5 ^ (n * 16'h1111)), 0);
        step(0, 0, 1, 1, 1'(s), 16'(16'h5E71 + n * 16'h0103), 0);
        step(0, 0, 0, 0, 0, 0, 1);
      end
    end
    tag = "R6";
    set_shift(8);
    step(0, 0, 1, 0, 0, 16'hAB00, 0);
    step(0, 0, 1, 0, 0, 16'hCD00, 0);
    step(0, 0, 1, 1, 0, 16'h00EF, 0);
    cmp("latch after no-push", pop_data, 16'h0000);
    step(0, 0, 0, 0, 0, 0, 1);
    // R7 R9: fill with wrap (pointers not at zero)
    tag = "R7";
    set_shift(4);
    for (int i = 0; i < 16; i++) begin
      if (i == 15) tag = "R9";
      step(0, 0, 1, 1, 1, 16'(16'h1000 + i * 16'h0111), 0);
    end
    cmp("full after 16", 16'(q_full), 16'd1);
    // R10: push while full dropped, latch still updated
    tag = "R10";
    step(0, 0, 1, 1, 1, 16'hDEAD, 0);
    step(0, 0, 1, 1, 1, 16'hBEEF, 0);
    // R11: push and pop together while full
    tag = "R11";
    step(0, 0, 1, 1, 0, 16'h7777, 1);
    step(0, 0, 1, 1, 1, 16'h0F0F, 1);
    // R8: drain in order
    tag = "R8";
    for (int i = 0; i < 16; i++) begin
      if (i == 0) tag = "R9";
      else tag = "R8";
      step(0, 0, 0, 0, 0, 0, 1);
    end
    // R10: pop on empty ignored
    tag = "R10";
    step(0, 0, 0, 0, 0, 0, 1);
    step(0, 0, 1, 1, 1, 16'h8001, 0);
    step(0, 0, 1, 1, 0, 16'h4002, 1);
    tag = "R11";
    step(0, 0, 1, 1, 1, 16'h2004, 1);
    step(0, 0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 0, 1);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule